// File: doc/BRIEF.md
# Half-Duty Two-Digit Display Multiplexer

This block time-shares one bank of 41 segment lines between two digit-select lines, so that 82 display segments are driven with only 43 outputs. A free-running frame counter advances on every clock, which is the oscillator-rate clock. Each frame is 4096 counts long and is split into two equal halves, one for each digit. During a digit's half the segment lines carry that digit's share of an 82-bit display word.

Brightness comes from a 10-bit dimmer code that sets how long the digit stays lit within its half. Every half starts with a short dark guard gap, which keeps the previous digit's pattern from ghosting into the next one. A blanking input and a sleep control override the display; sleep also freezes the frame counter.

Display words arrive from a serial receiver over a valid/ready stream with one pending slot. A word is accepted on a clock edge where valid and ready are both high. Ready is low while the slot holds a word that has not yet been shown. The pending word replaces the shown word only at a frame boundary, so a frame never mixes two words. The producer must hold valid and data stable until it sees ready. Ready never depends on valid.

Top module: `halfduty_disp_mux`

## Requirements
- R1: A frame is 4096 clock cycles. Counter positions 0 to 2047 form the digit-1 half and 2048 to 4095 the digit-2 half. Digit 1 turns on every 4096 cycles, and digit 2 turns on 2048 cycles after digit 1.
- R2: `digit_drv` is 2'b01 while digit 1 is lit and 2'b10 while digit 2 is lit. `seg_drv` then carries `seg_data` bits [40:0] or bits [81:41] of the shown word. All outputs are registered: they reflect the counter and the controls sampled at the previous clock edge.
- R3: Positions 0 to 15 of each half are a guard gap with every output off.
- R4: Past the guard gap, a digit is lit while (position within the half − 16) < 2 × `dim_code`. A code of 0 keeps the display dark. A code of 1016 or more lights the rest of the half.
- R5: While `blank` is 1, every digit and segment output is 0 on the next cycle. The frame counter keeps running.
- R6: While `sleep_ctl` is nonzero, every output is 0 on the next cycle and the frame counter holds its value.
- R7: A word is taken on an edge with `seg_valid` and `seg_ready` both high. `seg_ready` is 0 from the next cycle on. The word is first shown from position 0 of the following frame, and `seg_ready` returns to 1 after that same edge.
- R8: During and right after reset, the outputs are 0, `seg_ready` is 1 and the shown word is all zeros.
- R9: At most one digit output is active at a time, and `seg_drv` is 0 whenever no digit is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_ctl | input | 2 | Nonzero puts the block to sleep |
| blank | input | 1 | Forces every output off |
| dim_code | input | 10 | Brightness code |
| seg_valid | input | 1 | Display word offered |
| seg_ready | output | 1 | Pending slot is free |
| seg_data | input | 82 | Display word; bits [40:0] for digit 1, bits [81:41] for digit 2 |
| digit_drv | output | 2 | Digit select, one-hot or zero |
| seg_drv | output | 41 | Segment drive |

## Verification
A word handshake and a frame-boundary swap are exclusive, but the producer can be left waiting on a full slot until the swap frees it. The bench provokes this by offering a second word right after the first. The scoreboard then checks that ready comes back exactly one cycle after position 4095, and that the new word shows from the first lit cycle of the next frame. Blank and sleep are also raised together. The reference model judges that case by sleep taking precedence: the counter freezes and does not keep running as it does under blank alone.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
  localparam int unsigned HDM_GUARD_DEF = 16;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_BLANK = 2'b01,
    MODE_SLEEP = 2'b10
  } drive_mode_e;
endpackage

// File: rtl/hdm_frame_timer.sv
module hdm_frame_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = run && (&cnt_q);
endmodule

// File: rtl/hdm_on_window.sv
module hdm_on_window #(
  parameter int unsigned PHASE_W = 11,
  parameter int unsigned DIM_W   = 10,
  parameter int unsigned GUARD   = 16
) (
  input  logic [PHASE_W-1:0] pos,
  input  logic [DIM_W-1:0]   dim,
  output logic               lit
);
  localparam int          SHIFT   = int'(PHASE_W) - int'(DIM_W);
  localparam int unsigned EXT_W   = PHASE_W + 1;
  localparam logic [EXT_W-1:0] GUARD_V = EXT_W'(GUARD);

  logic [EXT_W-1:0] on_len;
  logic [EXT_W-1:0] pos_e;

  // Dimmer scaled to the phase length by a fixed shift, no multiplier.
  generate
    if (SHIFT >= 0) begin : g_up
      assign on_len = EXT_W'(dim) << SHIFT;
    end else begin : g_dn
      assign on_len = EXT_W'(dim >> (-SHIFT));
    end
  endgenerate

  assign pos_e = {1'b0, pos};
  assign lit   = (pos_e >= GUARD_V) && ((pos_e - GUARD_V) < on_len);
endmodule

// File: rtl/hdm_seg_buffer.sv
module hdm_seg_buffer #(
  parameter int unsigned DATA_W = 82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              swap,
  output logic [DATA_W-1:0] shown
);
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] shown_q;
  logic              full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      shown_q <= '0;
      full_q  <= 1'b0;
    end else if (in_valid && !full_q) begin
      pend_q <= in_data;
      full_q <= 1'b1;
    end else if (swap && full_q) begin
      shown_q <= pend_q;
      full_q  <= 1'b0;
    end
  end

  assign in_ready = !full_q;
  assign shown    = shown_q;
endmodule

// File: rtl/halfduty_disp_mux.sv
module halfduty_disp_mux
  import hdm_pkg::*;
#(
  parameter int unsigned SEG_W   = 41,
  parameter int unsigned DIGITS  = 2,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned DIM_W   = 10,
  parameter int unsigned GUARD   = HDM_GUARD_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              sleep_ctl,
  input  logic                    blank,
  input  logic [DIM_W-1:0]        dim_code,
  input  logic                    seg_valid,
  output logic                    seg_ready,
  input  logic [SEG_W*DIGITS-1:0] seg_data,
  output logic [DIGITS-1:0]       digit_drv,
  output logic [SEG_W-1:0]        seg_drv
);
  localparam int unsigned DSEL_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int unsigned PHASE_W = FRAME_W - DSEL_W;
  localparam int unsigned DATA_W  = SEG_W * DIGITS;

  logic [FRAME_W-1:0] frame_cnt;
  logic               wrap;
  logic               sleep_req;
  logic               lit;
  logic [DSEL_W-1:0]  phase_idx;
  logic [PHASE_W-1:0] pos;
  logic [DATA_W-1:0]  shown;
  logic [SEG_W-1:0]   seg_bank [DIGITS];
  logic [DIGITS-1:0]  dig_next;
  logic [SEG_W-1:0]   seg_next;
  drive_mode_e        mode;
  logic [DIGITS-1:0]  dig_q;
  logic [SEG_W-1:0]   seg_q;

  assign sleep_req = |sleep_ctl;
  assign phase_idx = frame_cnt[FRAME_W-1 -: DSEL_W];
  assign pos       = frame_cnt[PHASE_W-1:0];

  hdm_frame_timer #(.CNT_W(FRAME_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!sleep_req),
    .cnt   (frame_cnt),
    .wrap  (wrap)
  );

  hdm_on_window #(.PHASE_W(PHASE_W), .DIM_W(DIM_W), .GUARD(GUARD)) u_window (
    .pos (pos),
    .dim (dim_code),
    .lit (lit)
  );

  hdm_seg_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (seg_valid),
    .in_ready (seg_ready),
    .in_data  (seg_data),
    .swap     (wrap),
    .shown    (shown)
  );

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      assign seg_bank[d] = shown[d*SEG_W +: SEG_W];
      assign dig_next[d] = lit && (phase_idx == DSEL_W'(d));
    end
  endgenerate

  assign seg_next = seg_bank[phase_idx] & {SEG_W{lit}};

  always_comb begin
    if (sleep_req)  mode = MODE_SLEEP;
    else if (blank) mode = MODE_BLANK;
    else            mode = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      seg_q <= '0;
    end else begin
      case (mode)
        MODE_RUN: begin
          dig_q <= dig_next;
          seg_q <= seg_next;
        end
        default: begin
          dig_q <= '0;
          seg_q <= '0;
        end
      endcase
    end
  end

  assign digit_drv = dig_q;
  assign seg_drv   = seg_q;
endmodule

// File: rtl/hdm_checker.sv
module hdm_checker #(
  parameter int unsigned SEG_W   = 41,
  parameter int unsigned DIGITS  = 2,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned DIM_W   = 10,
  parameter int unsigned GUARD   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         sleep_ctl,
  input logic               blank,
  input logic [DIM_W-1:0]   dim_code,
  input logic               seg_valid,
  input logic               seg_ready,
  input logic [DIGITS-1:0]  digit_drv,
  input logic [SEG_W-1:0]   seg_drv,
  input logic [FRAME_W-1:0] frame_cnt
);
  localparam int unsigned PHASE_W = FRAME_W - ((DIGITS > 1) ? $clog2(DIGITS) : 1);

  logic [PHASE_W-1:0] pos;
  assign pos = frame_cnt[PHASE_W-1:0];

  a_r9_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(digit_drv) <= 1);

  a_r9_seg_needs_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_drv == '0) |-> (seg_drv == '0));

  a_r5_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (digit_drv == '0 && seg_drv == '0));

  a_r6_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ctl != 2'b00) |=> (digit_drv == '0 && seg_drv == '0));

  a_r6_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ctl != 2'b00) |=> $stable(frame_cnt));

  a_r3_guard_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (pos < PHASE_W'(GUARD)) |=> (digit_drv == '0));

  a_r4_zero_dim_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (dim_code == '0) |=> (digit_drv == '0));

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |=> !seg_ready);
endmodule

bind halfduty_disp_mux hdm_checker #(
  .SEG_W(SEG_W), .DIGITS(DIGITS), .FRAME_W(FRAME_W), .DIM_W(DIM_W), .GUARD(GUARD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_ctl (sleep_ctl),
  .blank     (blank),
  .dim_code  (dim_code),
  .seg_valid (seg_valid),
  .seg_ready (seg_ready),
  .digit_drv (digit_drv),
  .seg_drv   (seg_drv),
  .frame_cnt (frame_cnt)
);

// File: tb/halfduty_disp_mux_tb.sv
module halfduty_disp_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sleep_ctl = 2'b00;
  logic        blank = 1'b0;
  logic [9:0]  dim_code = 10'd0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [81:0] seg_data = '0;
  logic [1:0]  digit_drv;
  logic [40:0] seg_drv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  dig;
    logic [40:0] seg;
    logic        rdy;
    logic [3:0]  tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference model state, built from the requirements.
  int          mcnt = 0;
  bit          mfull = 0;
  logic [81:0] mpend = '0;
  logic [81:0] mshown = '0;

  always #4 clk = ~clk;

  halfduty_disp_mux u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_ctl (sleep_ctl),
    .blank     (blank),
    .dim_code  (dim_code),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_data  (seg_data),
    .digit_drv (digit_drv),
    .seg_drv   (seg_drv)
  );

  // Expected-item producer: one item per edge.
  always @(posedge clk) begin
    exp_t e;
    int   pos;
    int   ph;
    bit   lit;
    bit   acc;
    bit   swp;
    if (!rst_n) begin
      mcnt = 0; mfull = 0; mpend = '0; mshown = '0;
      e = '{dig: 2'b00, seg: '0, rdy: 1'b1, tag: 4'd8}; // R8
    end else begin
      pos = mcnt % 2048;
      ph  = mcnt / 2048;
      lit = (pos >= 16) && ((pos - 16) < 2 * int'(dim_code));
      if (sleep_ctl != 2'b00) begin
        e.dig = 2'b00; e.seg = '0; e.tag = 4'd6;          // R6
      end else if (blank) begin
        e.dig = 2'b00; e.seg = '0; e.tag = 4'd5;          // R5
      end else if (pos < 16) begin
        e.dig = 2'b00; e.seg = '0; e.tag = 4'd3;          // R3
      end else if (!lit) begin
        e.dig = 2'b00; e.seg = '0; e.tag = 4'd4;          // R4
      end else begin
        e.dig = (ph == 0) ? 2'b01 : 2'b10;                // R2
        e.seg = (ph == 0) ? mshown[40:0] : mshown[81:41];
        e.tag = 4'd2;
      end
      acc = seg_valid && !mfull;
      swp = (sleep_ctl == 2'b00) && (mcnt == 4095) && mfull;
      if (acc) begin mpend = seg_data; mfull = 1; end
      else if (swp) begin mshown = mpend; mfull = 0; end
      if (sleep_ctl == 2'b00) mcnt = (mcnt + 1) % 4096;
      e.rdy = !mfull;
    end
    exp_q.push_back(e);
  end

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if (digit_drv !== e.dig || seg_drv !== e.seg) begin
        n_fail++;
        $display("FAIL R%0d: dig=%b seg=%h expected dig=%b seg=%h", e.tag, digit_drv, seg_drv, e.dig, e.seg);
      end
      n_chk++;
      if (seg_ready !== e.rdy) begin
        n_fail++;
        $display("FAIL R7: ready=%b expected %b", seg_ready, e.rdy);
      end
      n_chk++;
      if ($countones(digit_drv) > 1 || (digit_drv == 2'b00 && seg_drv != '0)) begin
        n_fail++;
        $display("FAIL R9: dig=%b seg=%h expected one-hot digit, segments off when dark", digit_drv, seg_drv);
      end
    end
  end

  task automatic check_eq(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R7: waits for a free slot, then offers one word for one cycle.
  task automatic push_word(input logic [81:0] w);
    @(negedge clk);
    while (!seg_ready) @(negedge clk);
    seg_data  = w;
    seg_valid = 1'b1;
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  // R1: spacing of digit turn-ons.
  task automatic meas_frame();
    logic p;
    int   t1;
    int   t2;
    do begin p = digit_drv[0]; @(negedge clk); end while (!(digit_drv[0] && !p));
    t1 = 0;
    do begin p = digit_drv[1]; @(negedge clk); t1++; end while (!(digit_drv[1] && !p));
    t2 = 0;
    do begin p = digit_drv[0]; @(negedge clk); t2++; end while (!(digit_drv[0] && !p));
    check_eq("R1 digit-2 after digit-1", t1, 2048);
    check_eq("R1 frame period", t1 + t2, 4096);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    run_cyc(3);
    // R8: reset state
    check_eq("R8 digit off in reset", int'(digit_drv), 0);
    check_eq("R8 segments off in reset", int'(seg_drv != '0), 0);
    check_eq("R8 ready in reset", int'(seg_ready), 1);
    rst_n = 1'b1;
    run_cyc(2);

    dim_code = 10'd1023;
    push_word({41'h155_5555_5555, 41'h0AA_AAAA_AAAA});
    // R7: second word must wait for the frame swap
    push_word({41'h0F0_F0F0_F0F0, 41'h123_4567_89AB});
    run_cyc(2000);
    meas_frame();                    // R1
    dim_code = 10'd0;   run_cyc(4096);   // R4 dark
    dim_code = 10'd100; run_cyc(4096);   // R4 partial
    dim_code = 10'd1;   run_cyc(2100);   // R4 minimal
    dim_code = 10'd1016; run_cyc(4096);  // R4 full
    blank = 1'b1; run_cyc(3000);         // R5
    sleep_ctl = 2'b01; run_cyc(500);     // R5 and R6 together
    blank = 1'b0; sleep_ctl = 2'b10; run_cyc(300);
    push_word({41'h1FF_0000_FFFF, 41'h000_FFFF_0000}); // R7 during R6
    run_cyc(700);
    sleep_ctl = 2'b00; run_cyc(8300);
    push_word({41'h0AB_CDEF_0123, 41'h1CC_3333_CCCC});
    dim_code = 10'd600; run_cyc(5000);
    run_cyc(2);
    finish_run();
  end
endmodule